// File: doc/BRIEF.md
# Command Queue Segment Fetcher

This block drains an instruction queue that software keeps in memory as a chain of buffer segments. Software programs a starting segment pointer, a segment length in 64-bit words and a free-list pool number, then rings a doorbell with the number of whole instructions it has queued. While the doorbell count is non-zero, the block reads words one at a time over a simple request/response memory port. It packs each group of eight words into one instruction and hands that instruction downstream over a valid/ready interface.

The last word of every segment is a link word that holds the next segment's 128-byte-aligned pointer. When the fetcher reaches that word, it moves to the next segment and pulses a release event. The event carries the old segment's address and pool, so the old segment can be returned to its free list. Software may move the queue to a new buffer only while it is idle. A doorbell write that would exceed the count range is dropped and raises a sticky overflow flag.

Top module: `cmdq_fetch`

## Requirements
- R1: After reset, busy, db_count, issued_count, db_ovf_irq, ins_valid, rd_req_valid and free_valid are all 0.
- R2: A doorbell write adds db_add to db_count in the next cycle. busy is 1 exactly when db_count is non-zero.
- R3: A doorbell write is dropped if db_count, after that cycle's decrement, plus db_add would exceed 2^20-1. The write then sets db_ovf_irq, which stays 1 until reset.
- R4: The word at offset k of a segment whose pointer is P is read at byte address P*128 + 8*k. Only one read is outstanding at a time. A request holds its valid and address until it is accepted.
- R5: An instruction is eight consecutive non-link words. The word fetched first sits in ins_data[63:0] and word j sits in ins_data[64j+63:64j]. ins_valid and ins_data hold until ins_ready. Each acceptance lowers db_count by 1 and raises issued_count by 1.
- R6: The word at offset size-1 of each segment is a link word. Its bits [39:7] become the new segment pointer, fetching resumes at offset 0 of that segment, and the link word is never placed into an instruction. The segment size must be at least 2.
- R7: When a link word is consumed, free_valid pulses for one cycle with free_addr set to the exhausted segment's base byte address and free_pool set to the programmed pool.
- R8: A buffer write while db_count is 0 loads the pointer, size and pool. The next fetch starts at offset 0 of the new pointer.
- R9: A buffer write while db_count is non-zero leaves the pointer, size, pool and fetch progress unchanged, and leaves db_count unchanged.
- R10: Every buffer write clears issued_count in the next cycle, whatever db_count is.
- R11: No read request is made while db_count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| buf_wr | input | 1 | Buffer register write strobe |
| buf_ptr | input | 33 | Segment pointer, byte address bits [39:7] |
| buf_size | input | 13 | Segment length in 64-bit words, link word included |
| buf_pool | input | 3 | Free-list pool for released segments |
| db_wr | input | 1 | Doorbell write strobe |
| db_add | input | 20 | Number of instructions added |
| rd_req_valid | output | 1 | Word read request valid |
| rd_req_ready | input | 1 | Memory accepts request |
| rd_req_addr | output | 40 | Byte address of the requested word |
| rd_rsp_valid | input | 1 | Read response valid |
| rd_rsp_data | input | 64 | Read response word |
| ins_valid | output | 1 | Instruction valid |
| ins_ready | input | 1 | Downstream accepts instruction |
| ins_data | output | 512 | Eight packed instruction words |
| free_valid | output | 1 | Segment release pulse |
| free_addr | output | 40 | Released segment base byte address |
| free_pool | output | 3 | Pool of the released segment |
| busy | output | 1 | Queue has outstanding instructions |
| db_count | output | 20 | Outstanding doorbell count |
| issued_count | output | 32 | Instructions handed downstream since last buffer write |
| db_ovf_irq | output | 1 | Sticky doorbell overflow flag |

## Verification
The bench builds the block with its default parameters: 40-bit addresses, 13-bit sizes, a 20-bit doorbell and 8-word instructions. With those values a single doorbell write of 2^20-1 reaches the overflow edge directly. The bench sweeps every segment size from 2 to 10, so instructions straddle zero, one and several link words. It alternates free-flowing and throttled memory and downstream handshakes. In each run, every delivered word and every release event are predicted arithmetically from the chain the bench lays out. It also attempts a reprogram in mid-queue, with a decoy buffer in memory, to show the write is ignored.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_REQ     = 2'd1,
      ST_WAIT    = 2'd2,
      ST_PRESENT = 2'd3
   } fetch_st_e;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/cmdq_doorbell.sv
module cmdq_doorbell #(
   parameter int DB_W = 20
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            add_en,
   input  logic [DB_W-1:0] add_val,
   input  logic            take,
   output logic [DB_W-1:0] count,
   output logic            ovf
);

   logic [DB_W:0] after_take;
   logic [DB_W:0] after_add;
   logic          hit;

   always_comb begin
      after_take = {1'b0, count} - {{DB_W{1'b0}}, take};
      after_add  = after_take + {1'b0, add_val};
      hit        = add_en && after_add[DB_W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
         ovf   <= 1'b0;
      end else begin
         if (hit) begin
            count <= after_take[DB_W-1:0];
            ovf   <= 1'b1;
         end else if (add_en) begin
            count <= after_add[DB_W-1:0];
         end else begin
            count <= after_take[DB_W-1:0];
         end
      end
   end

endmodule

// File: rtl/cmdq_seg_walk.sv
module cmdq_seg_walk #(
   parameter int ADDR_W   = 40,
   parameter int LINE_LSB = 7,
   parameter int BYTE_LSB = 3,
   parameter int SIZE_W   = 13,
   parameter int POOL_W   = 3,
   localparam int PTR_W   = ADDR_W - LINE_LSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [PTR_W-1:0]  ld_ptr,
   input  logic [SIZE_W-1:0] ld_size,
   input  logic [POOL_W-1:0] ld_pool,
   input  logic              step,
   input  logic [PTR_W-1:0]  link_ptr,
   output logic [ADDR_W-1:0] word_addr,
   output logic              at_link,
   output logic              free_valid,
   output logic [ADDR_W-1:0] free_addr,
   output logic [POOL_W-1:0] free_pool
);

   logic [PTR_W-1:0]  base;
   logic [SIZE_W-1:0] seg_len;
   logic [POOL_W-1:0] pool;
   logic [SIZE_W-1:0] off;
   logic [ADDR_W-1:0] base_addr;

   always_comb begin
      base_addr = {base, {LINE_LSB{1'b0}}};
      word_addr = base_addr + (ADDR_W'(off) << BYTE_LSB);
      at_link   = (off == seg_len - SIZE_W'(1));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base       <= '0;
         seg_len    <= '0;
         pool       <= '0;
         off        <= '0;
         free_valid <= 1'b0;
         free_addr  <= '0;
         free_pool  <= '0;
      end else begin
         free_valid <= 1'b0;
         if (load) begin
            base    <= ld_ptr;
            seg_len <= ld_size;
            pool    <= ld_pool;
            off     <= '0;
         end else if (step) begin
            if (at_link) begin
               base       <= link_ptr;
               off        <= '0;
               free_valid <= 1'b1;
               free_addr  <= base_addr;
               free_pool  <= pool;
            end else begin
               off <= off + SIZE_W'(1);
            end
         end
      end
   end

endmodule

// File: rtl/cmdq_ins_asm.sv
module cmdq_ins_asm #(
   parameter int WORD_W      = 64,
   parameter int INSTR_WORDS = 8,
   localparam int WIDX_W     = cmdq_pkg::idx_width(INSTR_WORDS)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [WIDX_W-1:0]             wr_idx,
   input  logic [WORD_W-1:0]             wr_word,
   output logic [INSTR_WORDS*WORD_W-1:0] data
);

   for (genvar g = 0; g < INSTR_WORDS; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            data[g*WORD_W +: WORD_W] <= '0;
         end else if (wr_en && (wr_idx == WIDX_W'(g))) begin
            data[g*WORD_W +: WORD_W] <= wr_word;
         end
      end
   end

endmodule

// File: rtl/cmdq_fetch.sv
module cmdq_fetch #(
   parameter int ADDR_W      = 40,
   parameter int LINE_LSB    = 7,
   parameter int WORD_W      = 64,
   parameter int SIZE_W      = 13,
   parameter int POOL_W      = 3,
   parameter int DB_W        = 20,
   parameter int ICNT_W      = 32,
   parameter int INSTR_WORDS = 8,
   localparam int PTR_W      = ADDR_W - LINE_LSB,
   localparam int INS_W      = INSTR_WORDS * WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              buf_wr,
   input  logic [PTR_W-1:0]  buf_ptr,
   input  logic [SIZE_W-1:0] buf_size,
   input  logic [POOL_W-1:0] buf_pool,
   input  logic              db_wr,
   input  logic [DB_W-1:0]   db_add,
   output logic              rd_req_valid,
   input  logic              rd_req_ready,
   output logic [ADDR_W-1:0] rd_req_addr,
   input  logic              rd_rsp_valid,
   input  logic [WORD_W-1:0] rd_rsp_data,
   output logic              ins_valid,
   input  logic              ins_ready,
   output logic [INS_W-1:0]  ins_data,
   output logic              free_valid,
   output logic [ADDR_W-1:0] free_addr,
   output logic [POOL_W-1:0] free_pool,
   output logic              busy,
   output logic [DB_W-1:0]   db_count,
   output logic [ICNT_W-1:0] issued_count,
   output logic              db_ovf_irq
);
   import cmdq_pkg::*;

   localparam int BYTE_LSB = $clog2(WORD_W / 8);
   localparam int WIDX_W   = idx_width(INSTR_WORDS);
   localparam logic [WIDX_W-1:0] LAST_IDX = WIDX_W'(INSTR_WORDS - 1);

   if (WORD_W < ADDR_W) begin : g_err_link
      $error("a link word must be able to carry a full address");
   end
   if (LINE_LSB < BYTE_LSB) begin : g_err_align
      $error("segment alignment must be at least one word");
   end
   if (INSTR_WORDS < 1) begin : g_err_words
      $error("an instruction needs at least one word");
   end
   if ((WORD_W % 8) != 0) begin : g_err_bytes
      $error("word width must be whole bytes");
   end

   fetch_st_e         state;
   logic [WIDX_W-1:0] widx;
   logic              load;
   logic              step;
   logic              take;
   logic              at_link;
   logic              asm_wr;
   logic [ADDR_W-1:0] word_addr;

   always_comb begin
      load         = buf_wr && (db_count == '0) && (state == ST_IDLE);
      step         = (state == ST_WAIT) && rd_rsp_valid;
      asm_wr       = step && !at_link;
      take         = (state == ST_PRESENT) && ins_ready;
      rd_req_valid = (state == ST_REQ);
      rd_req_addr  = word_addr;
      ins_valid    = (state == ST_PRESENT);
      busy         = (db_count != '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         widx  <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (db_count != '0) state <= ST_REQ;
            end
            ST_REQ: begin
               if (rd_req_ready) state <= ST_WAIT;
            end
            ST_WAIT: begin
               if (rd_rsp_valid) begin
                  if (at_link) begin
                     state <= ST_REQ;
                  end else if (widx == LAST_IDX) begin
                     widx  <= '0;
                     state <= ST_PRESENT;
                  end else begin
                     widx  <= widx + WIDX_W'(1);
                     state <= ST_REQ;
                  end
               end
            end
            ST_PRESENT: begin
               if (ins_ready) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         issued_count <= '0;
      end else if (buf_wr) begin
         issued_count <= '0;
      end else if (take) begin
         issued_count <= issued_count + ICNT_W'(1);
      end
   end

   cmdq_doorbell #(
      .DB_W (DB_W)
   ) u_bell (
      .clk     (clk),
      .rst_n   (rst_n),
      .add_en  (db_wr),
      .add_val (db_add),
      .take    (take),
      .count   (db_count),
      .ovf     (db_ovf_irq)
   );

   cmdq_seg_walk #(
      .ADDR_W   (ADDR_W),
      .LINE_LSB (LINE_LSB),
      .BYTE_LSB (BYTE_LSB),
      .SIZE_W   (SIZE_W),
      .POOL_W   (POOL_W)
   ) u_walk (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .ld_ptr     (buf_ptr),
      .ld_size    (buf_size),
      .ld_pool    (buf_pool),
      .step       (step),
      .link_ptr   (rd_rsp_data[ADDR_W-1:LINE_LSB]),
      .word_addr  (word_addr),
      .at_link    (at_link),
      .free_valid (free_valid),
      .free_addr  (free_addr),
      .free_pool  (free_pool)
   );

   cmdq_ins_asm #(
      .WORD_W      (WORD_W),
      .INSTR_WORDS (INSTR_WORDS)
   ) u_asm (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (asm_wr),
      .wr_idx  (widx),
      .wr_word (rd_rsp_data),
      .data    (ins_data)
   );

endmodule

// File: rtl/cmdq_fetch_chk.sv
module cmdq_fetch_chk #(
   parameter int ADDR_W = 40,
   parameter int DB_W   = 20,
   parameter int ICNT_W = 32,
   parameter int INS_W  = 512
) (
   input logic              clk,
   input logic              rst_n,
   input logic              db_wr,
   input logic              buf_wr,
   input logic              rd_req_valid,
   input logic              rd_req_ready,
   input logic [ADDR_W-1:0] rd_req_addr,
   input logic              ins_valid,
   input logic              ins_ready,
   input logic [INS_W-1:0]  ins_data,
   input logic              free_valid,
   input logic [DB_W-1:0]   db_count,
   input logic [ICNT_W-1:0] issued_count,
   input logic              db_ovf_irq
);

   assert_no_fetch_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (db_count == '0) |-> !rd_req_valid);

   assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));

   assert_req_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_valid |-> (rd_req_addr[2:0] == 3'd0));

   assert_ins_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_valid && !ins_ready) |=> (ins_valid && $stable(ins_data)));

   assert_take_dec_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_valid && ins_ready && !db_wr) |=> (db_count == $past(db_count) - 1'b1));

   assert_sticky_ovf_R3: assert property (@(posedge clk) disable iff (!rst_n)
      db_ovf_irq |=> db_ovf_irq);

   assert_free_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      free_valid |=> !free_valid);

   assert_clear_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
      buf_wr |=> (issued_count == '0));

endmodule

bind cmdq_fetch cmdq_fetch_chk #(
   .ADDR_W (ADDR_W),
   .DB_W   (DB_W),
   .ICNT_W (ICNT_W),
   .INS_W  (INSTR_WORDS * WORD_W)
) u_chk (.*);

// File: tb/cmdq_fetch_tb.sv
module cmdq_fetch_tb;

   localparam int DBMAX = (1 << 20) - 1;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         buf_wr;
   logic [32:0]  buf_ptr;
   logic [12:0]  buf_size;
   logic [2:0]   buf_pool;
   logic         db_wr;
   logic [19:0]  db_add;
   logic         rd_req_valid;
   logic         rd_req_ready;
   logic [39:0]  rd_req_addr;
   logic         rd_rsp_valid;
   logic [63:0]  rd_rsp_data;
   logic         ins_valid;
   logic         ins_ready;
   logic [511:0] ins_data;
   logic         free_valid;
   logic [39:0]  free_addr;
   logic [2:0]   free_pool;
   logic         busy;
   logic [19:0]  db_count;
   logic [31:0]  issued_count;
   logic         db_ovf_irq;

   always #5 clk = ~clk;

   cmdq_fetch u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .buf_wr       (buf_wr),
      .buf_ptr      (buf_ptr),
      .buf_size     (buf_size),
      .buf_pool     (buf_pool),
      .db_wr        (db_wr),
      .db_add       (db_add),
      .rd_req_valid (rd_req_valid),
      .rd_req_ready (rd_req_ready),
      .rd_req_addr  (rd_req_addr),
      .rd_rsp_valid (rd_rsp_valid),
      .rd_rsp_data  (rd_rsp_data),
      .ins_valid    (ins_valid),
      .ins_ready    (ins_ready),
      .ins_data     (ins_data),
      .free_valid   (free_valid),
      .free_addr    (free_addr),
      .free_pool    (free_pool),
      .busy         (busy),
      .db_count     (db_count),
      .issued_count (issued_count),
      .db_ovf_irq   (db_ovf_irq)
   );

   int          checks = 0;
   int          failures = 0;
   int          cyc = 0;
   int          mode = 0;
   bit          track = 0;
   int          exp_seq = 0;
   int          free_seen = 0;
   int          cur_pool = 0;
   bit          pending = 0;
   logic [39:0] paddr;
   logic [63:0] mem [0:1023];
   bit          ins_ok;
   logic [63:0] bad_a;
   logic [63:0] bad_e;

   function automatic logic [63:0] pay(input int s);
      return 64'hC0DE_0000_0000_0000 | 64'(s);
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic fill(input int sz);
      int seq;
      seq = 0;
      for (int i = 0; i < 1024; i++) mem[i] = 64'd0;
      for (int j = 0; j < 30; j++) begin
         for (int k = 0; k < sz - 1; k++) begin
            mem[(j + 1) * 16 + k] = pay(seq);
            seq++;
         end
         mem[(j + 1) * 16 + sz - 1] = 64'((j + 2) * 128);
      end
   endtask

   task automatic buf_write(input int ptr, input int sz, input int pool);
      buf_ptr  = 33'(ptr);
      buf_size = 13'(sz);
      buf_pool = 3'(pool);
      buf_wr   = 1'b1;
      @(negedge clk);
      buf_wr   = 1'b0;
   endtask

   task automatic ring(input int n);
      db_add = 20'(n);
      db_wr  = 1'b1;
      @(negedge clk);
      db_wr  = 1'b0;
   endtask

   task automatic drain();
      while (db_count != 20'd0) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   // Memory model and downstream sink, all on the falling edge.
   initial begin
      rd_req_ready = 1'b0;
      rd_rsp_valid = 1'b0;
      rd_rsp_data  = 64'd0;
      ins_ready    = 1'b0;
      forever begin
         @(negedge clk);
         cyc++;
         rd_rsp_valid = 1'b0;
         if (!rst_n) begin
            pending = 1'b0;
         end else if (pending) begin
            rd_rsp_valid = 1'b1;
            rd_rsp_data  = mem[paddr[12:3]];
            pending      = 1'b0;
         end
         rd_req_ready = (mode == 1) ? (cyc % 2 == 0) : 1'b1;
         ins_ready    = (mode == 0) ? 1'b1 : (mode == 1) ? (cyc % 3 != 0) : 1'b0;
         if (rst_n && rd_req_valid && rd_req_ready) begin
            pending = 1'b1;
            paddr   = rd_req_addr;
         end
         if (rst_n && track && ins_valid && ins_ready) begin
            ins_ok = 1'b1;
            bad_a  = 64'd0;
            bad_e  = 64'd0;
            for (int w = 0; w < 8; w++) begin
               if (ins_data[w*64 +: 64] !== pay(exp_seq + w)) begin
                  ins_ok = 1'b0;
                  bad_a  = ins_data[w*64 +: 64];
                  bad_e  = pay(exp_seq + w);
               end
            end
            chk(ins_ok, "R5 R6 R4 instruction words", bad_a, bad_e);
            exp_seq += 8;
         end
         if (rst_n && track && free_valid) begin
            chk((free_addr == 40'((free_seen + 1) * 128)) && (free_pool == 3'(cur_pool)),
                "R7 release address and pool", 64'({free_pool, free_addr}),
                64'({3'(cur_pool), 40'((free_seen + 1) * 128)}));
            free_seen++;
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      rst_n    = 1'b0;
      buf_wr   = 1'b0;
      buf_ptr  = '0;
      buf_size = '0;
      buf_pool = '0;
      db_wr    = 1'b0;
      db_add   = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(!busy && db_count == 0 && issued_count == 0 && !db_ovf_irq,
          "R1 reset status", 64'({busy, db_ovf_irq, issued_count, db_count}), 64'd0);
      chk(!ins_valid && !rd_req_valid && !free_valid, "R1 reset handshakes",
          64'({ins_valid, rd_req_valid, free_valid}), 64'd0);

      // R8 sweep of segment sizes, reprogrammed each time while idle
      for (int s = 2; s <= 10; s++) begin
         mode      = s % 2;
         fill(s);
         exp_seq   = 0;
         free_seen = 0;
         cur_pool  = s % 8;
         track     = 1'b1;
         buf_write(1, s, s % 8);
         chk(issued_count == 0, "R10 cleared by write", 64'(issued_count), 64'd0);
         ring(3);
         chk(db_count == 3 && busy, "R2 doorbell add and busy", 64'(db_count), 64'd3);
         drain();
         chk(issued_count == 3 && exp_seq == 24, "R5 R8 instructions delivered",
             64'(issued_count), 64'd3);
         chk(free_seen == 23 / (s - 1), "R6 R7 link words consumed",
             64'(free_seen), 64'(23 / (s - 1)));
         chk(!busy, "R2 idle after drain", 64'(busy), 64'd0);
      end

      // R9 reprogram attempt while work is pending
      fill(5);
      for (int i = 640; i < 660; i++) mem[i] = 64'hDEAD_DEAD_DEAD_DEAD;
      mode      = 2;
      exp_seq   = 0;
      free_seen = 0;
      cur_pool  = 5;
      track     = 1'b1;
      buf_write(1, 5, 5);
      ring(3);
      while (!ins_valid) @(negedge clk);
      mode = 0;
      while (issued_count != 1) @(negedge clk);
      mode = 2;
      while (!ins_valid) @(negedge clk);
      buf_write(40, 3, 1);
      chk(issued_count == 0, "R10 cleared while busy", 64'(issued_count), 64'd0);
      chk(db_count == 2, "R9 doorbell untouched by write", 64'(db_count), 64'd2);
      mode = 0;
      drain();
      chk(exp_seq == 24 && issued_count == 2, "R9 original chain continued",
          64'(exp_seq), 64'd24);
      chk(free_seen == 5, "R9 R7 original pool and segments", 64'(free_seen), 64'd5);

      // R11 nothing fetched with an empty doorbell
      ins_ok = 1'b1;
      for (int i = 0; i < 10; i++) begin
         if (rd_req_valid) ins_ok = 1'b0;
         @(negedge clk);
      end
      chk(ins_ok, "R11 no request when idle", 64'(ins_ok), 64'd1);

      // R3 overflow
      track = 1'b0;
      mode  = 2;
      ring(DBMAX);
      chk(db_count == 20'(DBMAX) && busy, "R2 full doorbell", 64'(db_count), 64'(DBMAX));
      chk(!db_ovf_irq, "R3 no flag at limit", 64'(db_ovf_irq), 64'd0);
      ring(1);
      chk(db_ovf_irq && db_count == 20'(DBMAX), "R3 overflow dropped and flagged",
          64'({db_ovf_irq, db_count}), 64'({1'b1, 20'(DBMAX)}));
      repeat (5) @(negedge clk);
      chk(db_ovf_irq, "R3 flag sticky", 64'(db_ovf_irq), 64'd1);

      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!db_ovf_irq && db_count == 0 && !busy, "R1 reset clears flag",
          64'({db_ovf_irq, db_count}), 64'd0);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule